// File: doc/BRIEF.md
# Serial EEPROM Slave with Block Protection

This block is the logic of a byte-wide serial EEPROM that answers as a slave on an SPI bus. The serial pins are brought into the block's own clock domain through synchronisers. Clock edges are found by comparing consecutive samples. The design decodes a command byte, an optional two-byte address and then data bytes. Reads return bytes from an internal array, from a separate identification page or from the status register. Writes collect bytes in a page buffer. They are committed only when chip select rises on a byte boundary, and the commit runs as a self-timed busy period of a fixed number of system clocks.

Software protection fences off a fraction of the array. A write-protect pin, together with a status enable bit, freezes the status register. A sticky lock bit makes the identification page permanently read-only. A hold input pauses a transfer part-way through a byte without losing its position.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and `miso_en` is low.
- R2: Input is sampled on rising SCK and output changes on falling SCK, so a transfer returns the same data whether SCK idles low (mode 0) or high (mode 3) when chip select falls.
- R3: Opcode 0x06 sets the write-enable bit (status bit 1) and 0x04 clears it. A write (0x02), ID write (0x82) or status write (0x01) issued while that bit is clear is ignored. The bit clears when any committed write finishes.
- R4: Opcode 0x02, a 16-bit address (low ARRAY_AW bits used) and data bytes are committed when chip select rises. Status bit 0 reads 1 for WRITE_CYCLES clocks while the write-enable bit stays 1, and afterwards the data reads back.
- R5: While busy, every opcode except status read (0x05) is ignored, including 0x06 and 0x02.
- R6: Data bytes that run past the end of a 64-byte page wrap to the start of the same page.
- R7: Opcode 0x03 with an address streams bytes with an auto-incremented address, which wraps from the last array byte to address 0.
- R8: Status bits 3:2 select protection: 00 none, 01 upper quarter, 10 upper half, 11 whole array. Bytes aimed at protected addresses are discarded and the other bytes are still written.
- R9: With status bit 7 set and `wp_n` low, a status write is ignored (the write-enable bit stays set). With `wp_n` high it is accepted.
- R10: Opcodes 0x82 and 0x83 write and read a separate 64-byte identification page, with the address wrapping inside the page. Writing status bit 6 sets a lock that no later status write clears, and 0x82 is ignored while the lock is set.
- R11: While `hold_n` is low, SCK edges are ignored and `miso_en` is low. After release, the transfer continues at the same bit.
- R12: `miso_en` is high only during an output phase with chip select low. A write ended with chip select rising mid-byte is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the block |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Hardware write protect, active low |
| miso | output | 1 | Serial data out of the block |
| miso_en | output | 1 | Output enable for `miso`; low means high-impedance |

## Verification
A wrong bit counter or phase shows up as a byte that is shifted or mis-decoded, on the very next byte read back through the scoreboard. A wrong write-enable, busy, protection or lock state is invisible until a later status read or read-back returns it, which is one transaction after the faulty command. A hold that fails to freeze the counter corrupts the byte being read across the pause, so the bench places a hold inside a read byte and checks `miso_en` during the pause.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_RSTAT,
        PH_WSTAT,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        CK_MAIN,
        CK_ID,
        CK_STAT
    } commit_e;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDID = 8'h83;
    localparam logic [7:0] OP_WRID = 8'h82;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/eep_prot.sv
module eep_prot #(
    parameter int AW = 10
) (
    input  logic [1:0]    bp,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    always_comb begin
        unique case (bp)
            2'b00: hit = 1'b0;
            2'b01: hit = &addr[AW-1:AW-2];
            2'b10: hit = addr[AW-1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 10,
    parameter int PAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [7:0]     wdata,
    input  logic           id_we,
    input  logic [PAW-1:0] id_waddr,
    input  logic [AW-1:0]  raddr,
    output logic [7:0]     rdata,
    input  logic [PAW-1:0] id_raddr,
    output logic [7:0]     id_rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int IDEPTH = 1 << PAW;

    logic [7:0] main_mem [DEPTH];
    logic [7:0] id_mem [IDEPTH];

    always_ff @(posedge clk) begin
        if (we) main_mem[waddr] <= wdata;
        if (id_we) id_mem[id_waddr] <= wdata;
    end

    assign rdata = main_mem[raddr];
    assign id_rdata = id_mem[id_raddr];

    // R10
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && id_we));
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave #(
    parameter int ARRAY_AW = 10,
    parameter int PAGE_AW = 6,
    parameter int WRITE_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic miso,
    output logic miso_en
);
    import eep_pkg::*;

    localparam int AW = ARRAY_AW;
    localparam int PAGE = 1 << PAGE_AW;
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        phase_e                ph;
        logic [2:0]            bits;
        logic [7:0]            rx;
        logic [7:0]            cmd;
        logic                  abyte;
        logic [15:0]           addr;
        logic [PAGE-1:0][7:0]  pbuf;
        logic [PAGE-1:0]       pval;
        logic [AW-1:0]         pbase;
        logic [7:0]            sdat;
        logic                  sgot;
        logic [7:0]            tx_sr;
        logic [7:0]            tx_nxt;
        logic                  tx_ld;
        logic                  tx_on;
        logic                  miso;
        logic                  wel;
        logic [1:0]            bp;
        logic                  wpen;
        logic                  idlk;
        logic                  busy;
        logic [CW-1:0]         bcnt;
        commit_e               kind;
        logic                  sck_p;
        logic                  cs_p;
    } state_t;

    state_t q, d;

    logic cs_s, sck_s, mosi_s, hold_s, wp_s;
    logic rise, fall;
    logic [7:0] rxn, status;
    logic [15:0] addr_new;
    logic [AW-1:0] fetch;
    logic [7:0] mem_rd, id_rd;
    logic [PAGE_AW-1:0] cidx;
    logic [AW-1:0] wr_addr;
    logic mem_we, id_we, prot_hit;

    eep_sync #(.W(5), .STAGES(2), .RST_VAL(5'b11100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, hold_n, wp_n, sck, mosi}),
        .q({cs_s, hold_s, wp_s, sck_s, mosi_s})
    );

    assign cidx = q.bcnt[PAGE_AW-1:0];
    assign wr_addr = {q.pbase[AW-1:PAGE_AW], cidx};
    assign addr_new = {q.addr[7:0], rxn};
    assign fetch = (q.ph == PH_ADDR) ? addr_new[AW-1:0] : q.addr[AW-1:0];
    assign status = {q.wpen, q.idlk, 2'b00, q.bp, q.wel, q.busy};
    assign rxn = {q.rx[6:0], mosi_s};
    assign rise = sck_s & ~q.sck_p & ~cs_s & hold_s;
    assign fall = ~sck_s & q.sck_p & ~cs_s & hold_s;

    eep_prot #(.AW(AW)) u_prot (.bp(q.bp), .addr(wr_addr), .hit(prot_hit));

    eep_array #(.AW(AW), .PAW(PAGE_AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .we(mem_we), .waddr(wr_addr), .wdata(q.pbuf[cidx]),
        .id_we(id_we), .id_waddr(cidx),
        .raddr(fetch), .rdata(mem_rd),
        .id_raddr(fetch[PAGE_AW-1:0]), .id_rdata(id_rd)
    );

    always_comb begin
        d = q;
        mem_we = 1'b0;
        id_we = 1'b0;
        d.sck_p = sck_s;
        d.cs_p = cs_s;

        // self-timed commit: copy one buffered byte per clock, then idle out the period
        if (q.busy) begin
            if (int'(q.bcnt) < PAGE && q.pval[cidx]) begin
                if (q.kind == CK_MAIN && !prot_hit) mem_we = 1'b1;
                if (q.kind == CK_ID && !q.idlk) id_we = 1'b1;
            end
            if (q.bcnt == CW'(WRITE_CYCLES - 1)) begin
                d.busy = 1'b0;
                d.wel = 1'b0;
                d.bcnt = '0;
            end else begin
                d.bcnt = q.bcnt + 1'b1;
            end
        end

        if (cs_s) begin
            d.ph = PH_CMD;
            d.bits = '0;
            d.abyte = 1'b0;
            d.tx_on = 1'b0;
            d.tx_ld = 1'b0;
            if (!q.cs_p && q.bits == 3'd0) begin
                if (q.ph == PH_WDATA && |q.pval) begin
                    d.busy = 1'b1;
                    d.bcnt = '0;
                    d.kind = (q.cmd == OP_WRID) ? CK_ID : CK_MAIN;
                end else if (q.ph == PH_WSTAT && q.sgot && !(q.wpen && !wp_s)) begin
                    d.bp = q.sdat[3:2];
                    d.wpen = q.sdat[7];
                    d.idlk = q.idlk | q.sdat[6];
                    d.busy = 1'b1;
                    d.bcnt = '0;
                    d.kind = CK_STAT;
                end
            end
        end else begin
            if (rise) begin
                d.rx = rxn;
                d.bits = q.bits + 1'b1;
                if (q.bits == 3'd7) begin
                    unique case (q.ph)
                        PH_CMD: begin
                            d.cmd = rxn;
                            d.ph = PH_SKIP;
                            if (!q.busy || rxn == OP_RDSR) begin
                                unique case (rxn)
                                    OP_WREN: d.wel = 1'b1;
                                    OP_WRDI: d.wel = 1'b0;
                                    OP_RDSR: begin
                                        d.tx_nxt = status;
                                        d.tx_ld = 1'b1;
                                        d.ph = PH_RSTAT;
                                    end
                                    OP_WRSR: if (q.wel && !(q.wpen && !wp_s)) begin
                                        d.ph = PH_WSTAT;
                                        d.sgot = 1'b0;
                                    end
                                    OP_READ, OP_RDID: d.ph = PH_ADDR;
                                    OP_WRITE: if (q.wel) begin
                                        d.ph = PH_ADDR;
                                        d.pval = '0;
                                    end
                                    OP_WRID: if (q.wel && !q.idlk) begin
                                        d.ph = PH_ADDR;
                                        d.pval = '0;
                                    end
                                    default: d.ph = PH_SKIP;
                                endcase
                            end
                        end
                        PH_ADDR: begin
                            d.addr = addr_new;
                            d.abyte = 1'b1;
                            if (q.abyte) begin
                                if (q.cmd == OP_READ) begin
                                    d.tx_nxt = mem_rd;
                                    d.tx_ld = 1'b1;
                                    d.addr[AW-1:0] = addr_new[AW-1:0] + 1'b1;
                                    d.ph = PH_RDATA;
                                end else if (q.cmd == OP_RDID) begin
                                    d.tx_nxt = id_rd;
                                    d.tx_ld = 1'b1;
                                    d.addr[PAGE_AW-1:0] = addr_new[PAGE_AW-1:0] + 1'b1;
                                    d.ph = PH_RDATA;
                                end else begin
                                    d.pbase = addr_new[AW-1:0];
                                    d.ph = PH_WDATA;
                                end
                            end
                        end
                        PH_RDATA: begin
                            d.tx_ld = 1'b1;
                            if (q.cmd == OP_READ) begin
                                d.tx_nxt = mem_rd;
                                d.addr[AW-1:0] = q.addr[AW-1:0] + 1'b1;
                            end else begin
                                d.tx_nxt = id_rd;
                                d.addr[PAGE_AW-1:0] = q.addr[PAGE_AW-1:0] + 1'b1;
                            end
                        end
                        PH_RSTAT: begin
                            d.tx_nxt = status;
                            d.tx_ld = 1'b1;
                        end
                        PH_WDATA: begin
                            d.pbuf[q.addr[PAGE_AW-1:0]] = rxn;
                            d.pval[q.addr[PAGE_AW-1:0]] = 1'b1;
                            d.addr[PAGE_AW-1:0] = q.addr[PAGE_AW-1:0] + 1'b1;
                        end
                        PH_WSTAT: if (!q.sgot) begin
                            d.sdat = rxn;
                            d.sgot = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (fall) begin
                if (q.tx_ld) begin
                    d.miso = q.tx_nxt[7];
                    d.tx_sr = {q.tx_nxt[6:0], 1'b0};
                    d.tx_ld = 1'b0;
                    d.tx_on = 1'b1;
                end else if (q.tx_on) begin
                    d.miso = q.tx_sr[7];
                    d.tx_sr = {q.tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            q.cs_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign miso = q.miso;
    assign miso_en = q.tx_on & ~cs_s & hold_s;

    logic unused_bits;
    assign unused_bits = ^{q.addr[15:AW], q.pbase[PAGE_AW-1:0], q.sdat[5:4], q.sdat[1:0]};

    // R4
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> ($past(cs_s) && !$past(q.cs_p)));
    // R3
    wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> !q.wel);
    // R8
    prot_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (q.bp != 2'b11));
    // R8
    prot_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && q.bp == 2'b10) |-> !wr_addr[AW-1]);
    // R10
    id_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.idlk |=> q.idlk);
    // R9
    wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wpen && !wp_s) |=> $stable(q.bp));
    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !cs_s) |=> (cs_s || $stable(q.bits)));
endmodule

// File: tb/eep_spi_slave_bench.sv
module eep_spi_slave_bench;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic miso, miso_en;
    logic mode3 = 1'b0;

    int tests = 0;
    int fails = 0;
    logic [7:0] dbuf [64];
    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    eep_spi_slave #(.ARRAY_AW(10), .PAGE_AW(6), .WRITE_CYCLES(1200)) u_eep_spi_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .miso(miso), .miso_en(miso_en)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // monitor: pops the scoreboard as read bytes arrive
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                check8(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r, input int hold_at);
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) begin
                hold_n = 1'b0;
                waitc(6);
                sck = 1'b0; waitc(4); sck = 1'b1; waitc(4);
                sck = 1'b0; waitc(4); sck = 1'b1; waitc(4);
                check8("R11 miso_en during hold", {7'd0, miso_en}, 8'h00);
                hold_n = 1'b1;
                waitc(H);
            end
            sck = 1'b0;
            mosi = b[i];
            waitc(H);
            r[i] = miso;
            sck = 1'b1;
            waitc(H);
        end
    endtask

    task automatic cs_begin();
        sck = mode3;
        waitc(2);
        cs_n = 1'b0;
        waitc(H);
    endtask

    task automatic cs_end();
        if (!mode3) sck = 1'b0;
        waitc(H);
        cs_n = 1'b1;
        waitc(2 * H);
    endtask

    task automatic op1(input logic [7:0] op);
        logic [7:0] r;
        cs_begin(); xbyte(op, r, -1); cs_end();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] r;
        cs_begin(); xbyte(8'h05, r, -1); xbyte(8'h00, st, -1); cs_end();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        cs_begin(); xbyte(8'h01, r, -1); xbyte(v, r, -1); cs_end();
    endtask

    task automatic wait_ready();
        logic [7:0] st;
        for (int k = 0; k < 100; k++) begin
            rdsr(st);
            if (!st[0]) break;
        end
    endtask

    task automatic put_bytes(input logic [7:0] op, input logic [15:0] a, input int n);
        logic [7:0] r;
        cs_begin();
        xbyte(op, r, -1); xbyte(a[15:8], r, -1); xbyte(a[7:0], r, -1);
        for (int i = 0; i < n; i++) xbyte(dbuf[i], r, -1);
        cs_end();
    endtask

    task automatic get_bytes(input logic [7:0] op, input logic [15:0] a, input int n, input string tag);
        logic [7:0] r;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(dbuf[i]);
            tag_q.push_back(tag);
        end
        cs_begin();
        xbyte(op, r, -1); xbyte(a[15:8], r, -1); xbyte(a[7:0], r, -1);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r, -1);
            act_q.push_back(r);
        end
        cs_end();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [7:0] v);
        dbuf[0] = v;
        op1(8'h06);
        put_bytes(8'h02, a, 1);
        wait_ready();
    endtask

    task automatic rd1(input logic [15:0] a, input logic [7:0] v, input string tag);
        dbuf[0] = v;
        get_bytes(8'h03, a, 1, tag);
    endtask

    initial begin
        logic [7:0] st, r;
        waitc(5);
        rst_n = 1'b1;
        waitc(5);

        // R1 reset state
        check8("R1 miso_en idle", {7'd0, miso_en}, 8'h00);
        rdsr(st); check8("R1 status after reset", st, 8'h00);

        // R3 write without enable is ignored; enable / disable
        dbuf[0] = 8'hAA; put_bytes(8'h02, 16'h0010, 1);
        rdsr(st); check8("R3 write w/o enable", st, 8'h00);
        op1(8'h06); rdsr(st); check8("R3 enable sets bit1", st, 8'h02);
        op1(8'h04); rdsr(st); check8("R3 disable clears bit1", st, 8'h00);

        // R4 page write with busy
        op1(8'h06);
        dbuf[0] = 8'hA1; dbuf[1] = 8'hA2; dbuf[2] = 8'hA3;
        put_bytes(8'h02, 16'h0010, 3);
        rdsr(st); check8("R4 busy and enable during write", st, 8'h03);
        wait_ready();
        rdsr(st); check8("R4 R3 idle after write", st, 8'h00);
        dbuf[0] = 8'hA1; dbuf[1] = 8'hA2; dbuf[2] = 8'hA3;
        get_bytes(8'h03, 16'h0010, 3, "R4 readback");

        // R5 commands during busy are ignored
        op1(8'h06);
        dbuf[0] = 8'hB0; put_bytes(8'h02, 16'h0020, 1);
        op1(8'h06);
        dbuf[0] = 8'h55; put_bytes(8'h02, 16'h0010, 1);
        wait_ready();
        rd1(16'h0010, 8'hA1, "R5 write during busy ignored");
        rd1(16'h0020, 8'hB0, "R5 first write kept");

        // R6 page wrap
        op1(8'h06);
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44;
        put_bytes(8'h02, 16'h007E, 4);
        wait_ready();
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; get_bytes(8'h03, 16'h007E, 2, "R6 page tail");
        dbuf[0] = 8'h33; dbuf[1] = 8'h44; get_bytes(8'h03, 16'h0040, 2, "R6 wrapped to page start");

        // R7 sequential read wraps from last byte to 0
        wr1(16'h03FF, 8'h5A);
        wr1(16'h0000, 8'hA5);
        dbuf[0] = 8'h5A; dbuf[1] = 8'hA5; get_bytes(8'h03, 16'h03FF, 2, "R7 array wrap");

        // R2 mode 3
        mode3 = 1'b1;
        waitc(4);
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; get_bytes(8'h03, 16'h007E, 2, "R2 mode3 read");
        wr1(16'h0100, 8'hC3);
        rd1(16'h0100, 8'hC3, "R2 mode3 write");
        mode3 = 1'b0;
        sck = 1'b0;
        waitc(4);

        // R8 block protection
        wr1(16'h02FF, 8'h01);
        wr1(16'h0300, 8'h02);
        op1(8'h06); wrsr(8'h04); wait_ready();
        rdsr(st); check8("R8 quarter setting", st, 8'h04);
        wr1(16'h02FF, 8'h81);
        wr1(16'h0300, 8'h82);
        dbuf[0] = 8'h81; dbuf[1] = 8'h02; get_bytes(8'h03, 16'h02FF, 2, "R8 upper quarter");
        op1(8'h06); wrsr(8'h08); wait_ready();
        wr1(16'h02FF, 8'h91);
        wr1(16'h01FF, 8'h92);
        rd1(16'h02FF, 8'h81, "R8 upper half blocked");
        rd1(16'h01FF, 8'h92, "R8 lower half open");
        op1(8'h06); wrsr(8'h0C); wait_ready();
        wr1(16'h0000, 8'h77);
        rd1(16'h0000, 8'hA5, "R8 whole array");
        op1(8'h06); wrsr(8'h00); wait_ready();

        // R9 hardware write protect
        op1(8'h06); wrsr(8'h80); wait_ready();
        rdsr(st); check8("R9 enable bit set", st, 8'h80);
        wp_n = 1'b0;
        op1(8'h06); wrsr(8'h08); wait_ready();
        rdsr(st); check8("R9 status write blocked", st, 8'h82);
        wp_n = 1'b1;
        wrsr(8'h00); wait_ready();
        rdsr(st); check8("R9 status write accepted", st, 8'h00);

        // R10 identification page and lock
        op1(8'h06);
        dbuf[0] = 8'h3C; dbuf[1] = 8'h4D; put_bytes(8'h82, 16'h0005, 2);
        wait_ready();
        dbuf[0] = 8'h3C; dbuf[1] = 8'h4D; get_bytes(8'h83, 16'h0005, 2, "R10 id page");
        op1(8'h06); wrsr(8'h40); wait_ready();
        rdsr(st); check8("R10 lock set", st, 8'h40);
        op1(8'h06);
        dbuf[0] = 8'hFF; put_bytes(8'h82, 16'h0005, 1);
        wait_ready();
        dbuf[0] = 8'h3C; get_bytes(8'h83, 16'h0005, 1, "R10 locked id write ignored");
        rdsr(st); check8("R10 id write skipped", st, 8'h42);
        wrsr(8'h00); wait_ready();
        rdsr(st); check8("R10 lock sticky", st, 8'h40);

        // R11 hold mid-byte, R12 output enable
        cs_begin();
        xbyte(8'h03, r, -1); xbyte(8'h00, r, -1); xbyte(8'h10, r, -1);
        xbyte(8'h00, r, 3);
        check8("R11 byte across hold", r, 8'hA1);
        sck = 1'b0; waitc(H);
        check8("R12 miso_en in output phase", {7'd0, miso_en}, 8'h01);
        xbyte(8'h00, r, -1);
        check8("R11 next byte after hold", r, 8'hA2);
        cs_end();
        check8("R12 miso_en after cs high", {7'd0, miso_en}, 8'h00);

        // R12 partial byte aborts write
        op1(8'h06);
        cs_begin();
        xbyte(8'h02, r, -1); xbyte(8'h00, r, -1); xbyte(8'h10, r, -1);
        for (int i = 0; i < 4; i++) begin
            sck = 1'b0; mosi = 1'b1; waitc(H); sck = 1'b1; waitc(H);
        end
        cs_end();
        rdsr(st); check8("R12 partial write not committed", st, 8'h42);
        rd1(16'h0010, 8'hA1, "R12 data unchanged");

        waitc(20);
        report();
    end
endmodule